// File: doc/BRIEF.md
# I2C Register Slave with Strapped Device Address

This block is an I2C-bus target that lets an external bus master read and write a small internal register file. Its 7-bit bus address has a fixed upper part (`01110` by default). The two lowest address bits are taken from a pair of pins that do double duty. While reset is asserted the block leaves these pins undriven, so board resistors set their level. The block captures that level as reset ends. From then on it drives the pins with two signals from elsewhere on the chip.

A write transfer begins with a subaddress byte, which loads an internal register pointer. Every byte after it is stored at the pointer, and the pointer then advances. A read transfer returns bytes from the current pointer, so a master normally writes the subaddress first and then issues a repeated START to read. The pointer advances after every byte and wraps around at the end of the register space. A STOP abandons any transfer at any point. The chip side gets a registered read port into the same register file.

SCL and SDA are open-drain lines. The block sees each line as a level input and pulls SDA low through a single drive-low enable. Both lines are resynchronised to the system clock, which must run at least eight times faster than SCL.

Top module: `i2c_strap_regslave`

## Requirements
- R1: The block acknowledges an address byte by pulling SDA low in the ninth clock only when the upper seven bits equal {DEV_HI, A1, A0}. For any other address it does not drive SDA again until the next START.
- R2: A1:A0 equal the strap pin inputs (bit 1 = A1, bit 0 = A0) as sampled in the last cycle with `rst` high. Later activity on those pins does not change the address.
- R3: While `rst` is high both strap output enables are 0. From the second cycle after `rst` falls both enables are 1, and each strap output follows its `gen_i` bit with one cycle of latency.
- R4: In a write transfer, the low ADDR_W bits of the first byte after the address load the pointer. Each later byte is stored at the pointer, and the pointer then increments.
- R5: In a read transfer, each byte returned MSB first is the register at the pointer, and the pointer increments after every byte.
- R6: The pointer wraps from 2^ADDR_W-1 to 0 for both writes and reads.
- R7: Every byte written after a matching address (subaddress and data) is acknowledged.
- R8: After the master answers a read byte with NACK, the block leaves SDA released until the next START, even if SCL keeps toggling.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle at any point. A data byte cut short by a STOP is not stored.
- R10: A repeated START restarts address reception and keeps the pointer, so a read after a subaddress-only write begins at that subaddress.
- R11: `app_rdata` returns the register selected by `app_addr` one clock later.
- R12: The block does not pull SDA low during reset. After reset the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its falling edge latches the strap bits |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_pin_i | input | 2 | Levels seen on the two shared strap pins |
| strap_pin_o | output | 2 | Drive values for the shared pins after reset |
| strap_pin_oe | output | 2 | Output enables for the shared pins |
| gen_i | input | 2 | Signal generator outputs routed to the shared pins |
| app_addr | input | ADDR_W | Chip-side register read address |
| app_rdata | output | 8 | Chip-side register read data, one cycle latency |

## Verification
The bench strings random write and read bursts against a register model. It also covers directed cases: a burst that crosses the top of the register space, a write cut short by STOP partway through a byte, a repeated START between the subaddress write and the read, and extra SCL clocks after a master NACK. A design that wraps the pointer badly would return the wrong byte after the wrap. A design that stores partial bytes would corrupt a register that reads back later. A design that keeps driving after a NACK would pull low bits that should read as 1. The strap pins switch to generator outputs after reset, and a second reset with different straps must move the answering address. A latch that stayed transparent would make the block answer at the wrong address or stop acknowledging.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchroniser for one open-drain line; keeps one extra stage for edge detection.
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], line_i};
  end

  assign lvl_o  = chain[STAGES-1];
  assign prev_o = chain[STAGES];
endmodule

// File: rtl/i2c_strap_pins.sv
// Captures strap levels during reset, then hands the pins to the generators.
module i2c_strap_pins #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] gen_i,
  output logic [NPINS-1:0] strap_q,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        strap_q[g] <= pin_i[g];
        pin_oe[g]  <= 1'b0;
        pin_o[g]   <= 1'b0;
      end else begin
        pin_oe[g]  <= 1'b1;
        pin_o[g]   <= gen_i[g];
      end
    end
  end
endmodule

// File: rtl/i2c_rs_regfile.sv
// Register storage: port A read/write (bus side), port B read-only (chip side).
module i2c_rs_regfile #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/i2c_rs_engine.sv
// Bus protocol engine: address match, pointer handling, byte shifting.
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter int           AW     = 4,
  parameter logic [4:0]   DEV_HI = 5'b01110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  input  logic [1:0]        dev_lo,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [AW-1:0]     ptr,
  output logic              we,
  output logic [BYTE_W-1:0] wdata,
  output slv_state_t        state
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              first;
  logic              mack;

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      ptr    <= '0;
      we     <= 1'b0;
      wdata  <= '0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + 1'b1;
      if (start_c) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_ADDR) begin
                if (sh[7:1] == {DEV_HI, dev_lo}) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WR_ACK;
                if (first) begin
                  ptr   <= sh[AW-1:0];
                  first <= 1'b0;
                end else begin
                  we    <= 1'b1;
                  wdata <= sh;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                state  <= ST_RD;
                sda_oe <= ~rd_data[BYTE_W-1];
                tx     <= {rd_data[BYTE_W-2:0], 1'b0};
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
                first  <= 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise && cnt != FULL) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
                ptr    <= ptr + 1'b1;
              end else begin
                sda_oe <= ~tx[BYTE_W-1];
                tx     <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                cnt    <= '0;
                state  <= ST_RD;
                sda_oe <= ~rd_data[BYTE_W-1];
                tx     <= {rd_data[BYTE_W-2:0], 1'b0};
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_strap_regslave.sv
module i2c_strap_regslave
  import i2c_rs_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter logic [4:0] DEV_HI      = 5'b01110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_pin_i,
  output logic [1:0]        strap_pin_o,
  output logic [1:0]        strap_pin_oe,
  input  logic [1:0]        gen_i,
  input  logic [ADDR_W-1:0] app_addr,
  output logic [BYTE_W-1:0] app_rdata
);
  logic              scl_s, scl_p, sda_s, sda_p;
  logic [1:0]        dev_lo;
  logic [ADDR_W-1:0] reg_ptr;
  logic              reg_we;
  logic [BYTE_W-1:0] reg_wdata;
  logic [BYTE_W-1:0] reg_rdata;
  slv_state_t        fsm_state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i), .lvl_o(scl_s), .prev_o(scl_p)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i), .lvl_o(sda_s), .prev_o(sda_p)
  );

  i2c_strap_pins #(.NPINS(2)) u_strap (
    .clk(clk), .rst(rst), .pin_i(strap_pin_i), .gen_i(gen_i),
    .strap_q(dev_lo), .pin_o(strap_pin_o), .pin_oe(strap_pin_oe)
  );

  i2c_rs_engine #(.AW(ADDR_W), .DEV_HI(DEV_HI)) u_engine (
    .clk(clk), .rst(rst),
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .dev_lo(dev_lo), .rd_data(reg_rdata),
    .sda_oe(sda_oe), .ptr(reg_ptr), .we(reg_we), .wdata(reg_wdata),
    .state(fsm_state)
  );

  i2c_rs_regfile #(.AW(ADDR_W), .DW(BYTE_W)) u_regs (
    .clk(clk),
    .a_we(reg_we), .a_addr(reg_ptr), .a_wdata(reg_wdata), .a_rdata(reg_rdata),
    .b_addr(app_addr), .b_rdata(app_rdata)
  );
endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker
  import i2c_rs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [1:0] strap_pin_oe,
  input logic [1:0] dev_lo,
  input logic       reg_we,
  input slv_state_t fsm_state
);
  AST_STRAP_HIZ_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> strap_pin_oe == 2'b00); // R3
  AST_STRAP_DRIVEN_AFTER: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> strap_pin_oe == 2'b11); // R3
  AST_ADDR_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dev_lo)); // R2
  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i); // R1
  AST_STORE_IS_ACKED: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> sda_oe); // R7
  AST_IDLE_RELEASES_SDA: assert property (@(posedge clk) disable iff (rst)
    fsm_state == ST_IDLE |-> !sda_oe); // R9
endmodule

bind i2c_strap_regslave i2c_rs_checker u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .strap_pin_oe(strap_pin_oe), .dev_lo(dev_lo), .reg_we(reg_we),
  .fsm_state(fsm_state)
);

// File: tb/tb_i2c_strap_regslave.sv
`timescale 1ns/1ps
module tb_i2c_strap_regslave;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl_m = 1'b1;
  logic          sda_m = 1'b1;
  logic          sda_line;
  logic          sda_oe;
  logic [1:0]    strap_drv = 2'b00;
  logic [1:0]    strap_pin_i, strap_pin_o, strap_pin_oe;
  logic [1:0]    gen_i = 2'b00;
  logic [AW-1:0] app_addr = '0;
  logic [7:0]    app_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]    model [DEPTH];
  logic [AW-1:0] mptr;
  logic [7:0]    wbuf [8];

  always #2 clk = ~clk;

  assign sda_line    = sda_m & ~sda_oe;
  assign strap_pin_i = strap_pin_oe & strap_pin_o | ~strap_pin_oe & strap_drv;

  i2c_strap_regslave #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_pin_i(strap_pin_i), .strap_pin_o(strap_pin_o),
    .strap_pin_oe(strap_pin_oe), .gen_i(gen_i),
    .app_addr(app_addr), .app_rdata(app_rdata)
  );

  function automatic logic [6:0] dev_of(input logic [1:0] s);
    return {5'b01110, s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    r = sda_line; tick(Q / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic more, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~more, r);
  endtask

  // address + subaddress + n data bytes, no STOP
  task automatic wr_burst(input logic [6:0] dev, input logic [7:0] sub, input int n);
    logic ack;
    bus_start;
    put_byte({dev, 1'b0}, ack);
    check("R1 address ack", 32'(ack), 32'd1);
    put_byte(sub, ack);
    check("R7 subaddress ack", 32'(ack), 32'd1);
    mptr = sub[AW-1:0];
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], ack);
      check("R7 data ack", 32'(ack), 32'd1);
      model[mptr] = wbuf[i];
      mptr = mptr + 1'b1;
    end
  endtask

  task automatic rd_burst(input logic [6:0] dev, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start;
    put_byte({dev, 1'b1}, ack);
    check("R1 read address ack", 32'(ack), 32'd1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      check(req, 32'(d), 32'(model[mptr]));
      mptr = mptr + 1'b1;
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst = 1'b1; strap_drv = s; tick(6);
    check("R3 strap oe in reset", 32'(strap_pin_oe), 32'd0);
    check("R12 no sda drive in reset", 32'(sda_oe), 32'd0);
    rst = 1'b0; mptr = '0;
    tick(3);
    check("R3 strap oe after reset", 32'(strap_pin_oe), 32'h3);
    check("R12 sda released after reset", 32'(sda_oe), 32'd0);
  endtask

  initial begin
    logic ack, r;
    logic [7:0] d;
    void'($urandom(32'd20240605));
    tick(2);
    do_reset(2'b00);

    // R3: generator outputs reach the pins
    for (int i = 0; i < 4; i++) begin
      gen_i = 2'($urandom);
      tick(2);
      check("R3 strap pin follows generator", 32'(strap_pin_o), 32'(gen_i));
    end

    // fill all registers at the unstrapped address (R4), pins now toggling (R2)
    for (int blk = 0; blk < DEPTH / 8; blk++) begin
      for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
      wr_burst(dev_of(2'b00), 8'(blk * 8), 8);
      bus_stop;
    end

    // R1/R2: other strap values are not answered
    for (int s = 1; s < 4; s++) begin
      bus_start;
      put_byte({dev_of(2'(s)), 1'b0}, ack);
      check("R1 R2 foreign address not acked", 32'(ack), 32'd0);
      put_byte(8'h00, ack);
      check("R1 no drive after mismatch", 32'(ack), 32'd0);
      bus_stop;
    end

    // R10: subaddress write, repeated START, read
    wr_burst(dev_of(2'b00), 8'h05, 0);
    rd_burst(dev_of(2'b00), 4, "R10 R5 read after repeated start");
    bus_stop;

    // R8: after NACK further clocks see a released SDA
    for (int i = 0; i < 9; i++) begin
      bus_start; bus_stop;
      break;
    end
    wr_burst(dev_of(2'b00), 8'h02, 0);
    rd_burst(dev_of(2'b00), 1, "R5 single byte read");
    for (int i = 0; i < 9; i++) begin
      bus_bit(1'b1, r);
      check("R8 released after nack", 32'(r), 32'd1);
    end
    bus_stop;

    // R6: write and read across the top of the register space
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    wr_burst(dev_of(2'b00), 8'(DEPTH - 2), 4);
    bus_stop;
    wr_burst(dev_of(2'b00), 8'(DEPTH - 2), 0);
    rd_burst(dev_of(2'b00), 4, "R6 read across wrap");
    bus_stop;

    // R9: data byte cut by STOP after four bits is not stored
    wr_burst(dev_of(2'b00), 8'h03, 0);
    for (int i = 0; i < 4; i++) bus_bit(~model[3][7 - i], r);
    bus_stop;
    check("R9 idle after stop", 32'(sda_oe), 32'd0);
    wr_burst(dev_of(2'b00), 8'h03, 0);
    rd_burst(dev_of(2'b00), 1, "R9 partial byte not stored");
    bus_stop;

    // R4: upper subaddress bits beyond ADDR_W are dropped
    wbuf[0] = 8'($urandom);
    wr_burst(dev_of(2'b00), 8'hA7, 1);
    bus_stop;
    wr_burst(dev_of(2'b00), 8'h07, 0);
    rd_burst(dev_of(2'b00), 1, "R4 subaddress low bits");
    bus_stop;

    // random bursts
    for (int k = 0; k < 20; k++) begin
      int n;
      logic [7:0] sub;
      n = 1 + int'($urandom % 5);
      sub = 8'($urandom);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_burst(dev_of(2'b00), sub, n);
      bus_stop;
      sub = 8'($urandom);
      n = 1 + int'($urandom % 5);
      wr_burst(dev_of(2'b00), sub, 0);
      rd_burst(dev_of(2'b00), n, "R5 random read back");
      bus_stop;
    end

    // R11: chip-side read port
    for (int i = 0; i < DEPTH; i++) begin
      app_addr = AW'(i);
      tick(2);
      check("R11 app read port", 32'(app_rdata), 32'(model[i]));
    end

    // R2/R12: new strap value, pointer cleared
    do_reset(2'b10);
    bus_start;
    put_byte({dev_of(2'b00), 1'b0}, ack);
    check("R2 old address ignored after restrap", 32'(ack), 32'd0);
    bus_stop;
    strap_drv = 2'b01;
    rd_burst(dev_of(2'b10), 2, "R12 pointer zero after reset");
    bus_stop;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule